// File: doc/BRIEF.md
# Ping-Pong Integrator Sequencer

This block sequences the two integrator halves (side A and side B) that sit behind each input of a current-integrating converter front end. While one side integrates the sensor current, the other side is being measured, reset and auto-zeroed. The controller steps through eight states. The level of a conversion-request input `conv` drives it, together with an internal busy flag from a modelled measurement timer. That timer starts a measure cycle on one side when it receives a one-clock start strobe, and it stays busy for `MEAS_CYCLES` clocks.

When the measure cycle always finishes before `conv` changes level again, the sides swap with no gap and the block stays in continuous mode. When `conv` changes level while a measurement is still busy, the block drops to non-continuous operation. In that mode it stops all integration, finishes the outstanding measurements one side after the other, prepares the next side for one clock, and then restarts integration. At reset the block picks its starting state from the level of `conv`.

Top module: `pingpong_int_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the state code becomes 1 if `conv` is high and 8 if `conv` is low. Both enables and both strobes are low.
- R2: `state_code` carries the state number 1..8. `cont_mode` is high exactly in states 3, 4, 5 and 6.
- R3: `int_a_en` is high only in states 3 and 5. `int_b_en` is high only in states 4 and 6. Neither is high in states 1, 2, 7 or 8.
- R4: State 3 moves to 4 at the first edge where `conv` is low and otherwise stays. State 6 moves to 5 at the first edge where `conv` is high and otherwise stays. States 2 and 7 last exactly one clock and then enter 3 and 6 respectively.
- R5: In state 4 with `conv` high, the next state is 5 if no measurement is busy and 1 if one is busy. In state 5 with `conv` low, the next state is 4 if idle and 8 if busy.
- R6: `meas_go_a` pulses for one clock in the first cycle of state 4. `meas_go_b` pulses for one clock in the first cycle of state 5. In a finish state entered from the opposite continuous state, the strobe for the second side pulses once the first measurement ends. The two strobes are never high together.
- R7: A measurement is busy for exactly `MEAS_CYCLES` clocks, counting the strobe cycle as the first. A new strobe is never issued while a measurement is busy.
- R8: State 1 waits while a measurement is busy. If state 1 was entered from state 4, it then starts side B and waits for that measurement too. Once nothing is outstanding, it goes to 2 if `conv` is high and to 8 if `conv` is low. State 8 does the same with the sides swapped: it starts side A if entered from 5, and exits to 7 on `conv` low or to 1 on `conv` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| conv | input | 1 | Conversion request level, synchronous to `clk` |
| int_a_en | output | 1 | Side A integrating |
| int_b_en | output | 1 | Side B integrating |
| meas_go_a | output | 1 | One-clock start of a side A measure cycle |
| meas_go_b | output | 1 | One-clock start of a side B measure cycle |
| cont_mode | output | 1 | High in continuous mode (states 3 to 6) |
| state_code | output | 4 | Current state number, 1 to 8 |

## Verification
The assertions assume that `conv` is already synchronous to `clk` and stable around each rising edge. They also assume that `MEAS_CYCLES` is at least one, which elaboration enforces. The bench drives `conv` only on falling edges and holds it steady across reset. It reads every output on the falling edge too, so each level it applies is what the next rising edge sees. The cycle-exact timing of the swap and fallback checks rests on the default `MEAS_CYCLES` of six, which the bench mirrors as its own constant.

// File: rtl/pp_seq_pkg.sv
package pp_seq_pkg;

   localparam int STATE_CODE_W = 4;

   // state numbers are visible on the state_code port
   typedef enum logic [STATE_CODE_W-1:0] {
      ST_FIN_A       = 4'd1,
      ST_PREP_A      = 4'd2,
      ST_INT_A       = 4'd3,
      ST_INTB_MEAS_A = 4'd4,
      ST_INTA_MEAS_B = 4'd5,
      ST_INT_B       = 4'd6,
      ST_PREP_B      = 4'd7,
      ST_FIN_B       = 4'd8
   } seq_state_t;

endpackage

// File: rtl/pp_meas_timer.sv
module pp_meas_timer #(
   parameter int MEAS_CYCLES = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_a,
   input  logic start_b,
   output logic busy
);

   generate
      if (MEAS_CYCLES == 1) begin : g_single
         // the strobe cycle is the whole measurement
         assign busy = start_a | start_b;
      end else begin : g_count
         localparam int CNT_W = $clog2(MEAS_CYCLES);
         localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(MEAS_CYCLES - 1);

         logic [CNT_W-1:0] remain;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               remain <= '0;
            end else if (start_a || start_b) begin
               remain <= LOAD_VAL;
            end else if (remain != '0) begin
               remain <= remain - 1'b1;
            end
         end

         assign busy = start_a | start_b | (remain != '0);
      end
   endgenerate

endmodule

// File: rtl/pp_seq_fsm.sv
module pp_seq_fsm
   import pp_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       conv,
   input  logic       busy,
   output seq_state_t cur_st,
   output logic       go_a,
   output logic       go_b
);

   seq_state_t nxt_st;
   logic       pend, nxt_pend;
   logic       nxt_go_a, nxt_go_b;

   always_comb begin
      nxt_st   = cur_st;
      nxt_pend = pend;
      nxt_go_a = 1'b0;
      nxt_go_b = 1'b0;
      unique case (cur_st)
         ST_FIN_A: begin
            if (!busy) begin
               if (pend) begin
                  nxt_go_b = 1'b1;
                  nxt_pend = 1'b0;
               end else begin
                  nxt_st = conv ? ST_PREP_A : ST_FIN_B;
               end
            end
         end
         ST_FIN_B: begin
            if (!busy) begin
               if (pend) begin
                  nxt_go_a = 1'b1;
                  nxt_pend = 1'b0;
               end else begin
                  nxt_st = conv ? ST_FIN_A : ST_PREP_B;
               end
            end
         end
         ST_PREP_A: nxt_st = ST_INT_A;
         ST_PREP_B: nxt_st = ST_INT_B;
         ST_INT_A: begin
            if (!conv) begin
               nxt_st   = ST_INTB_MEAS_A;
               nxt_go_a = 1'b1;
            end
         end
         ST_INT_B: begin
            if (conv) begin
               nxt_st   = ST_INTA_MEAS_B;
               nxt_go_b = 1'b1;
            end
         end
         ST_INTB_MEAS_A: begin
            if (conv) begin
               if (busy) begin
                  nxt_st   = ST_FIN_A;
                  nxt_pend = 1'b1;
               end else begin
                  nxt_st   = ST_INTA_MEAS_B;
                  nxt_go_b = 1'b1;
               end
            end
         end
         ST_INTA_MEAS_B: begin
            if (!conv) begin
               if (busy) begin
                  nxt_st   = ST_FIN_B;
                  nxt_pend = 1'b1;
               end else begin
                  nxt_st   = ST_INTB_MEAS_A;
                  nxt_go_a = 1'b1;
               end
            end
         end
         default: nxt_st = conv ? ST_FIN_A : ST_FIN_B;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_st <= conv ? ST_FIN_A : ST_FIN_B;
         pend   <= 1'b0;
         go_a   <= 1'b0;
         go_b   <= 1'b0;
      end else begin
         cur_st <= nxt_st;
         pend   <= nxt_pend;
         go_a   <= nxt_go_a;
         go_b   <= nxt_go_b;
      end
   end

endmodule

// File: rtl/pingpong_int_seq.sv
module pingpong_int_seq
   import pp_seq_pkg::*;
#(
   parameter int MEAS_CYCLES = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    conv,
   output logic                    int_a_en,
   output logic                    int_b_en,
   output logic                    meas_go_a,
   output logic                    meas_go_b,
   output logic                    cont_mode,
   output logic [STATE_CODE_W-1:0] state_code
);

   generate
      if (MEAS_CYCLES < 1) begin : g_bad_meas_cycles
         $error("pingpong_int_seq: MEAS_CYCLES must be at least 1");
      end
   endgenerate

   seq_state_t cur_st;
   logic       meas_busy;

   pp_seq_fsm u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .conv   (conv),
      .busy   (meas_busy),
      .cur_st (cur_st),
      .go_a   (meas_go_a),
      .go_b   (meas_go_b)
   );

   pp_meas_timer #(
      .MEAS_CYCLES (MEAS_CYCLES)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_a (meas_go_a),
      .start_b (meas_go_b),
      .busy    (meas_busy)
   );

   always_comb begin
      int_a_en  = (cur_st == ST_INT_A) || (cur_st == ST_INTA_MEAS_B);
      int_b_en  = (cur_st == ST_INT_B) || (cur_st == ST_INTB_MEAS_A);
      cont_mode = (cur_st == ST_INT_A) || (cur_st == ST_INTB_MEAS_A) ||
                  (cur_st == ST_INTA_MEAS_B) || (cur_st == ST_INT_B);
   end

   assign state_code = cur_st;

endmodule

// File: rtl/pp_seq_chk.sv
module pp_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       conv,
   input logic       int_a_en,
   input logic       int_b_en,
   input logic       meas_go_a,
   input logic       meas_go_b,
   input logic       cont_mode,
   input logic [3:0] state_code,
   input logic       meas_busy
);

   p_enables_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(int_a_en && int_b_en));

   p_mode_has_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cont_mode == (int_a_en || int_b_en));

   p_strobe_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({meas_go_a, meas_go_b}));

   p_prep_a_one_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 4'd2) |=> (state_code == 4'd3));

   p_prep_b_one_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 4'd7) |=> (state_code == 4'd6));

   p_swap_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 4'd4 && conv && !meas_busy) |=> (state_code == 4'd5 && meas_go_b));

   p_fallback_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 4'd5 && !conv && meas_busy) |=> (state_code == 4'd8 && !int_a_en && !int_b_en));

   p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (meas_go_a || meas_go_b) |-> !$past(meas_busy));

   p_fin_waits_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 4'd1 && meas_busy) |=> (state_code == 4'd1));

endmodule

bind pingpong_int_seq pp_seq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .conv       (conv),
   .int_a_en   (int_a_en),
   .int_b_en   (int_b_en),
   .meas_go_a  (meas_go_a),
   .meas_go_b  (meas_go_b),
   .cont_mode  (cont_mode),
   .state_code (state_code),
   .meas_busy  (meas_busy)
);

// File: tb/pingpong_int_seq_test.sv
`timescale 1ns/1ps
module pingpong_int_seq_test;

   localparam int BENCH_MEAS = 6;
   localparam int NROWS      = 51;
   localparam int WATCHDOG   = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       conv = 1'b0;
   logic       int_a_en, int_b_en, meas_go_a, meas_go_b, cont_mode;
   logic [3:0] state_code;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   pingpong_int_seq #(.MEAS_CYCLES(BENCH_MEAS)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .conv       (conv),
      .int_a_en   (int_a_en),
      .int_b_en   (int_b_en),
      .meas_go_a  (meas_go_a),
      .meas_go_b  (meas_go_b),
      .cont_mode  (cont_mode),
      .state_code (state_code)
   );

   // row: {conv to drive, expected state, int_a, int_b, go_a, go_b, cont}
   localparam logic [9:0] TBL [0:NROWS-1] = '{
      {1'b1, 4'd2, 5'b00000},  // 1
      {1'b1, 4'd3, 5'b10001},
      {1'b0, 4'd3, 5'b10001},
      {1'b0, 4'd4, 5'b01101},  // 4 strobe A
      {1'b0, 4'd4, 5'b01001},
      {1'b0, 4'd4, 5'b01001},
      {1'b0, 4'd4, 5'b01001},
      {1'b0, 4'd4, 5'b01001},
      {1'b0, 4'd4, 5'b01001},  // 9 last busy cycle
      {1'b1, 4'd4, 5'b01001},  // 10 idle, request swap
      {1'b1, 4'd5, 5'b10011},  // 11 swap, strobe B
      {1'b1, 4'd5, 5'b10001},
      {1'b1, 4'd5, 5'b10001},
      {1'b1, 4'd5, 5'b10001},
      {1'b1, 4'd5, 5'b10001},
      {1'b0, 4'd5, 5'b10001},  // 16 toggle while busy
      {1'b0, 4'd8, 5'b00000},  // 17 fallback
      {1'b0, 4'd8, 5'b00100},  // 18 pending side A starts
      {1'b0, 4'd8, 5'b00000},
      {1'b0, 4'd8, 5'b00000},
      {1'b0, 4'd8, 5'b00000},
      {1'b0, 4'd8, 5'b00000},
      {1'b0, 4'd8, 5'b00000},
      {1'b0, 4'd8, 5'b00000},  // 24 idle
      {1'b0, 4'd7, 5'b00000},  // 25 prepare B
      {1'b0, 4'd6, 5'b01001},
      {1'b1, 4'd6, 5'b01001},
      {1'b1, 4'd5, 5'b10011},  // 28 strobe B
      {1'b1, 4'd5, 5'b10001},
      {1'b1, 4'd5, 5'b10001},
      {1'b1, 4'd5, 5'b10001},
      {1'b1, 4'd5, 5'b10001},
      {1'b1, 4'd5, 5'b10001},
      {1'b0, 4'd5, 5'b10001},  // 34 idle, request swap
      {1'b0, 4'd4, 5'b01101},  // 35 swap, strobe A
      {1'b1, 4'd4, 5'b01001},  // 36 early toggle
      {1'b1, 4'd1, 5'b00000},  // 37 fallback
      {1'b1, 4'd1, 5'b00000},
      {1'b1, 4'd1, 5'b00000},
      {1'b1, 4'd1, 5'b00000},
      {1'b1, 4'd1, 5'b00000},
      {1'b1, 4'd1, 5'b00010},  // 42 pending side B starts
      {1'b1, 4'd1, 5'b00000},
      {1'b1, 4'd1, 5'b00000},
      {1'b1, 4'd1, 5'b00000},
      {1'b1, 4'd1, 5'b00000},
      {1'b1, 4'd1, 5'b00000},
      {1'b1, 4'd1, 5'b00000},  // 48 idle
      {1'b1, 4'd2, 5'b00000},
      {1'b0, 4'd3, 5'b10001},
      {1'b0, 4'd4, 5'b01101}   // 51
   };

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic chk_idle_outputs(input string tag);
      chk(tag, "enables", {int_a_en, int_b_en}, 0);
      chk(tag, "strobes", {meas_go_a, meas_go_b}, 0);
      chk(tag, "cont_mode", cont_mode, 0);
   endtask

   task automatic do_reset(input logic lvl);
      @(negedge clk);
      rst_n = 1'b0;
      conv  = lvl;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      // R1: reset with conv low selects state 8
      do_reset(1'b0);
      chk("R1", "reset state conv low", state_code, 8);
      chk_idle_outputs("R1");

      // R8: state 8 with nothing pending and conv high goes to 1, then 2
      rst_n = 1'b1;
      conv  = 1'b1;
      @(negedge clk);
      chk("R8", "8 exits to 1 on conv high", state_code, 1);
      @(negedge clk);
      chk("R8", "1 exits to 2 on conv high", state_code, 2);
      @(negedge clk);
      chk("R4", "2 lasts one clock then 3", state_code, 3);
      chk("R3", "int_a in state 3", {int_a_en, int_b_en}, 2);

      // R8 / R4: power-up in 8 with conv low prepares B
      do_reset(1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8", "8 exits to 7 on conv low", state_code, 7);
      chk_idle_outputs("R3");
      @(negedge clk);
      chk("R4", "7 lasts one clock then 6", state_code, 6);
      chk("R3", "int_b in state 6", {int_a_en, int_b_en}, 1);
      chk("R2", "cont_mode in state 6", cont_mode, 1);
      @(negedge clk);
      chk("R4", "6 holds while conv low", state_code, 6);

      // R1: reset level follows conv while held in reset
      do_reset(1'b0);
      chk("R1", "reset state conv low", state_code, 8);
      conv = 1'b1;
      @(negedge clk);
      chk("R1", "reset state follows conv high", state_code, 1);
      chk_idle_outputs("R1");

      // table walk: R4 R5 R7 R8 via state, R2 R3 R6 via flags
      rst_n = 1'b1;
      for (int i = 0; i < NROWS; i++) begin
         @(negedge clk);
         chk("R4 R5 R7 R8", $sformatf("row %0d state", i + 1), state_code, TBL[i][8:5]);
         chk("R3", $sformatf("row %0d enables", i + 1), {int_a_en, int_b_en}, TBL[i][4:3]);
         chk("R6", $sformatf("row %0d strobes", i + 1), {meas_go_a, meas_go_b}, TBL[i][2:1]);
         chk("R2", $sformatf("row %0d cont_mode", i + 1), cont_mode, TBL[i][0]);
         conv = TBL[i][9];
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule